// File: doc/BRIEF.md
# Major and Minor Phase Sequencer

This block produces the timing states for a small hardwired-control processor. A one-hot minor phase counter steps through four phases, T0 to T3, one clock each. A major-state register selects among Fetch, Defer and Execute. The major state can change only on the clock edge that ends T3.

The path out of Fetch depends on the instruction that has just been fetched. Instructions that complete inside Fetch go straight back to Fetch. Instructions that need extra cycles go to Execute. Memory-addressing instructions with the indirect bit set pass through Defer first. A conditional branch that is not taken goes back to Fetch.

A run flip-flop gates all advancement. A start pulse sets the run flip-flop and begins at (Fetch, T0). A halt request seen at (Fetch, T3) clears the run flip-flop and parks the sequencer at (Fetch, T0).

Top module: `phase_sequencer`

## Requirements
- R1: While `rst_n` is low and after its release, the state is T0 (`t_phase` = 4'b0001), major state Fetch (`mstate` = 2'b00, `mf` = 1), and `running` = 0.
- R2: A high `start` at a clock edge sets `running` and forces (Fetch, T0). This has priority over a halt request and over normal advancement.
- R3: While running, `t_phase` steps one bit per clock in the order 0001, 0010, 0100, 1000, then back to 0001. Exactly one bit is high at all times.
- R4: While `running` is 0 and `start` is low, neither `t_phase` nor `mstate` changes.
- R5: The major state is encoded 00 = Fetch, 01 = Defer, 10 = Execute. `mf`, `md` and `me` are one-hot copies of it, and a code of 11 reads as Fetch. `mstate` changes only on the edge that ends T3.
- R6: At the end of (Fetch, T3), an opcode whose two top bits are not 01 leads back to Fetch.
- R7: At the end of (Fetch, T3), an opcode whose two top bits are 01 leads to Execute. The exception is an opcode whose three top bits are 011 with `ind_bit` = 1, which leads to Defer. `ind_bit` has no effect on opcodes starting with 010.
- R8: For opcode 5'b01111, `br_taken` = 0 leads from Fetch back to Fetch whatever `ind_bit` is. `br_taken` = 1 follows R7.
- R9: Defer is always followed by Execute, and Execute is always followed by Fetch.
- R10: A `halt_req` at the edge ending (Fetch, T3) clears `running` and leaves (Fetch, T0). `halt_req` at any other phase or major state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse: set run, go to (Fetch, T0) |
| halt_req | input | 1 | Halt request, taken at (Fetch, T3) |
| opcode | input | 5 | Opcode field of the instruction register |
| ind_bit | input | 1 | Indirect-address bit of the instruction register |
| br_taken | input | 1 | Branch condition result |
| t_phase | output | 4 | One-hot minor phase, bit 0 = T0 |
| mstate | output | 2 | Encoded major state |
| mf | output | 1 | Fetch active |
| md | output | 1 | Defer active |
| me | output | 1 | Execute active |
| running | output | 1 | Run flip-flop |

## Verification
All results are registered, so every output is due one clock edge after the inputs that cause it. The bench drives inputs on the falling edge. It then steps a behavioural model by one clock and compares all outputs at the next falling edge, which is half a period after the edge that updates the design. The major-state outcome of an instruction therefore shows up exactly at the T0 sample that follows its (Fetch, T3) cycle. Stimulus covers every routing case out of Fetch, halts at and away from (Fetch, T3), and restarts in the middle of an instruction.

// File: rtl/phase_sequencer.sv
module phase_sequencer #(
  parameter int OP_W = 5,
  parameter int PH_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            halt_req,
  input  logic [OP_W-1:0] opcode,
  input  logic            ind_bit,
  input  logic            br_taken,
  output logic [PH_N-1:0] t_phase,
  output logic [1:0]      mstate,
  output logic            mf,
  output logic            md,
  output logic            me,
  output logic            running
);
  localparam logic [1:0] MS_F = 2'b00;
  localparam logic [1:0] MS_D = 2'b01;
  localparam logic [1:0] MS_E = 2'b10;
  localparam logic [PH_N-1:0] PH_FIRST = {{(PH_N-1){1'b0}}, 1'b1};
  localparam logic [OP_W-1:0] OP_BRANCH = {2'b01, {(OP_W-2){1'b1}}};

  logic [PH_N-1:0] phase_q;
  logic [1:0]      maj_q, maj_nx;
  logic            run_q;
  logic            last_ph, in_f, halt_hit;

  assign last_ph  = phase_q[PH_N-1];
  assign in_f     = (maj_q == MS_F) || (maj_q == 2'b11);
  assign halt_hit = halt_req && in_f && last_ph;

  always_comb begin
    maj_nx = MS_F;
    case (maj_q)
      MS_D: maj_nx = MS_E;
      MS_E: maj_nx = MS_F;
      default: begin
        if (opcode[OP_W-1 -: 2] != 2'b01)
          maj_nx = MS_F;
        else if (opcode == OP_BRANCH && !br_taken)
          maj_nx = MS_F;
        else if (opcode[OP_W-3] && ind_bit)
          maj_nx = MS_D;
        else
          maj_nx = MS_E;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      maj_q   <= MS_F;
      run_q   <= 1'b0;
    end else if (start) begin
      phase_q <= PH_FIRST;
      maj_q   <= MS_F;
      run_q   <= 1'b1;
    end else if (run_q) begin
      if (halt_hit) begin
        phase_q <= PH_FIRST;
        maj_q   <= MS_F;
        run_q   <= 1'b0;
      end else begin
        phase_q <= {phase_q[PH_N-2:0], phase_q[PH_N-1]};
        if (last_ph) maj_q <= maj_nx;
      end
    end
  end

  assign t_phase = phase_q;
  assign mstate  = maj_q;
  assign mf      = in_f;
  assign md      = (maj_q == MS_D);
  assign me      = (maj_q == MS_E);
  assign running = run_q;
endmodule

// File: rtl/phase_sequencer_chk.sv
module phase_sequencer_chk #(
  parameter int PH_N = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            halt_req,
  input logic [PH_N-1:0] t_phase,
  input logic [1:0]      mstate,
  input logic            mf,
  input logic            md,
  input logic            me,
  input logic            running
);
  localparam logic [PH_N-1:0] PH_FIRST = {{(PH_N-1){1'b0}}, 1'b1};

  a_r3_onehot_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(t_phase) == 1);

  a_r5_onehot_major: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mf, md, me}) == 1);

  a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && !(halt_req && mf && t_phase[PH_N-1]))
    |=> t_phase == {$past(t_phase[PH_N-2:0]), $past(t_phase[PH_N-1])});

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> ($stable(t_phase) && $stable(mstate) && !running));

  a_r5_major_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !t_phase[PH_N-1]) |=> $stable(mstate));

  a_r9_defer_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && md && t_phase[PH_N-1]) |=> me);

  a_r9_exec_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && me && t_phase[PH_N-1]) |=> mf);

  a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && halt_req && mf && t_phase[PH_N-1])
    |=> (!running && mf && t_phase == PH_FIRST));

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && mstate == 2'b00 && t_phase == PH_FIRST));
endmodule

bind phase_sequencer phase_sequencer_chk #(.PH_N(PH_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .halt_req(halt_req),
  .t_phase(t_phase), .mstate(mstate), .mf(mf), .md(md), .me(me),
  .running(running)
);

// File: tb/sim_phase_sequencer.sv
module sim_phase_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, halt_req = 1'b0, ind_bit = 1'b0, br_taken = 1'b0;
  logic [4:0] opcode = 5'b00000;
  logic [3:0] t_phase;
  logic [1:0] mstate;
  logic mf, md, me, running;

  int checks = 0, errors = 0;
  int m_minor = 0, m_major = 0, m_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .halt_req(halt_req),
    .opcode(opcode), .ind_bit(ind_bit), .br_taken(br_taken),
    .t_phase(t_phase), .mstate(mstate), .mf(mf), .md(md), .me(me),
    .running(running)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, int'(t_phase), 1 << m_minor, "t_phase");
    chk(tag, int'(mstate), m_major, "mstate");
    chk(tag, int'({mf, md, me}), (m_major == 0) ? 4 : (m_major == 1) ? 2 : 1, "mf/md/me");
    chk(tag, int'(running), m_run, "running");
  endtask

  function automatic int next_major(input int maj);
    if (maj == 1) return 2;
    if (maj == 2) return 0;
    if (opcode[4:3] != 2'b01) return 0;
    if (opcode == 5'b01111 && !br_taken) return 0;
    if (opcode[2] && ind_bit) return 1;
    return 2;
  endfunction

  task automatic tick(input string tag);
    if (start) begin
      m_minor = 0; m_major = 0; m_run = 1;
    end else if (m_run == 1) begin
      if (halt_req && m_major == 0 && m_minor == 3) begin
        m_run = 0; m_minor = 0; m_major = 0;
      end else begin
        if (m_minor == 3) m_major = next_major(m_major);
        m_minor = (m_minor + 1) % 4;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic instr(input logic [4:0] op, input logic ib, input logic bt, input string tag);
    opcode = op; ind_bit = ib; br_taken = bt;
    for (int i = 0; i < 4; i++) tick(tag);
  endtask

  task automatic do_start();
    start = 1'b1;
    tick("R2");
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    for (int i = 0; i < 3; i++) tick("R4");
    do_start();
    instr(5'b10101, 1'b1, 1'b0, "R6");
    instr(5'b00011, 1'b0, 1'b1, "R6");
    instr(5'b11001, 1'b0, 1'b0, "R6");
    instr(5'b01000, 1'b1, 1'b0, "R7");
    instr(5'b01000, 1'b1, 1'b0, "R9");
    instr(5'b01100, 1'b0, 1'b0, "R7");
    instr(5'b00000, 1'b0, 1'b0, "R9");
    instr(5'b01101, 1'b1, 1'b0, "R7");
    instr(5'b00000, 1'b0, 1'b0, "R9");
    instr(5'b00000, 1'b0, 1'b0, "R9");
    instr(5'b01111, 1'b1, 1'b0, "R8");
    instr(5'b01111, 1'b0, 1'b1, "R8");
    instr(5'b00000, 1'b0, 1'b0, "R9");
    instr(5'b01111, 1'b1, 1'b1, "R8");
    halt_req = 1'b1;
    instr(5'b00000, 1'b0, 1'b0, "R10");
    instr(5'b00000, 1'b0, 1'b0, "R10");
    halt_req = 1'b0;
    instr(5'b01010, 1'b0, 1'b0, "R5");
    halt_req = 1'b1;
    instr(5'b00000, 1'b0, 1'b0, "R10");
    halt_req = 1'b0;
    instr(5'b10000, 1'b0, 1'b0, "R3");
    halt_req = 1'b1;
    instr(5'b10000, 1'b0, 1'b0, "R10");
    halt_req = 1'b0;
    for (int i = 0; i < 5; i++) tick("R4");
    do_start();
    opcode = 5'b01110; ind_bit = 1'b1;
    for (int i = 0; i < 6; i++) tick("R7");
    start = 1'b1; halt_req = 1'b1;
    tick("R2");
    start = 1'b0; halt_req = 1'b0;
    instr(5'b01011, 1'b1, 1'b0, "R7");
    instr(5'b01011, 1'b1, 1'b0, "R9");
    instr(5'b10110, 1'b0, 1'b0, "R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule